// File: doc/BRIEF.md
# Banked Pin Controller with Bitwise Masked Writes

This block controls one bank of general-purpose pins, split into ports of eight pins each (four ports by default, 32 pins). Software reaches it over a plain 32-bit register bus. For every port it holds a pin-enable byte, a drive-enable byte, a drive-value byte, an interrupt-enable byte, a three-lane interrupt-type word and a status byte. It also exposes the synchronised pad inputs and a write-only clear port. Each writable group has a second, masked address. A write there carries a per-bit update mask next to the data, so one pin can change without a read-modify-write sequence.

Every pad input passes through a two-flop synchroniser and then through an edge or level detector. The detector is chosen per pin by its type lanes. A status bit that is set and enabled raises the single bank interrupt line. Pads are driven only when both the pin-enable bit and the drive-enable bit of the pin are 1.

Top module: `pinbank_ctrl`

## Requirements
- R1: Address decoding works as follows. bus_addr[3:2] selects the port. bus_addr[6:4] selects the group: 0 pin-enable, 1 drive-enable, 2 drive-value, 3 input, 4 status, 5 interrupt-enable, 6 type, 7 clear. bus_addr[7]=1 selects the masked alias. A read returns data on bus_rdata after the next rising edge, with the port's byte in bits [7:0] and zeros above.
- R2: A masked write to the pin-enable, drive-enable, drive-value, interrupt-enable or status group updates pin n of the addressed port to wdata[n] only where wdata[8+n] is 1. Every other pin keeps its value.
- R3: Each port's type word carries polarity in bits [7:0], edge mode in bits [15:8] and both-edge mode in bits [23:16]. It reads back in the same layout. Its masked alias takes the per-pin update mask from wdata[31:24] and updates all three lanes of the selected pins.
- R4: pad_oe[i] is 1 exactly when the pin-enable bit and the drive-enable bit of pin i are both 1. pad_out[i] equals the drive value where pad_oe[i] is 1, and is 0 elsewhere.
- R5: The input group reads the pad value after two clock stages of synchronisation, whatever the drive-enable setting is.
- R6: For a pin with edge mode set, the status bit latches on a synchronised rising edge (polarity 1), a falling edge (polarity 0), or either edge (both-edge set). It then holds until software clears it. A detected edge wins over a clear in the same cycle.
- R7: For a pin with edge mode clear, the status bit follows the synchronised input level. It reads 1 while the input is high (polarity 1) or low (polarity 0), and a clear write cannot remove it.
- R8: Writing 1 to bit n of the clear group removes the latched status of pin n. A 0 bit has no effect. The clear group reads as 0.
- R9: irq is the OR over all pins of status AND interrupt-enable. After reset every register is 0, so all interrupt-enable bits are 0 and irq is 0.
- R10: Reset is asserted asynchronously and released synchronously. A write during the first two rising edges after rst_n goes high is lost.
- R11: Plain writes to the input and status groups, and masked writes to the input and clear groups, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad inputs, asynchronous to clk |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad drive enables; 0 releases the pad |
| irq | output | 1 | Combined bank interrupt |

## Verification
The hardest case to reach from the ports is a synchronised edge that arrives in the same cycle as a clear write for that pin. Hitting it means counting the three register stages between a pad change and the status update. The bench therefore changes the pad, waits one falling edge and then issues the clear, so that both land on the same rising edge. A cycle-accurate behavioural model runs beside the design and is compared on every clock. This covers the reset-time level-low status, the changes of type while a status bit is latched, and pseudo-random pad traffic with every detection mode active at once.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  typedef enum logic [2:0] {
    GRP_PEN  = 3'd0,
    GRP_DEN  = 3'd1,
    GRP_DVAL = 3'd2,
    GRP_IN   = 3'd3,
    GRP_STS  = 3'd4,
    GRP_IEN  = 3'd5,
    GRP_TYPE = 3'd6,
    GRP_CLR  = 3'd7
  } grp_e;

  typedef struct packed {
    logic plain;
    logic masked;
    grp_e grp;
  } wr_cmd_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  // STAGES synchroniser flops plus one history flop for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [WIDTH-1:0] chain_q [DEPTH];
  logic [WIDTH-1:0] chain_d [DEPTH];

  always_comb begin
    chain_d[0] = raw_i;
    for (int s = 1; s < DEPTH; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) chain_q[s] <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) chain_q[s] <= chain_d[s];
    end
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] both_i,
  output logic [WIDTH-1:0] evt_o,
  output logic [WIDTH-1:0] lvl_o
);

  logic [WIDTH-1:0] rise, fall;

  always_comb begin
    rise  = cur_i & ~prev_i;
    fall  = ~cur_i & prev_i;
    evt_o = (both_i & (rise | fall))
          | (~both_i & pol_i & rise)
          | (~both_i & ~pol_i & fall);
    lvl_o = ~(cur_i ^ pol_i);
  end

endmodule

// File: rtl/port_regs.sv
module port_regs
  import pinbank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  wr_cmd_t      cmd_i,
  input  logic [31:0]  wdata_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  output logic [W-1:0] pen_o,
  output logic [W-1:0] den_o,
  output logic [W-1:0] dval_o,
  output logic [W-1:0] ien_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] both_o,
  output logic [W-1:0] sts_o
);

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                         input logic [W-1:0] en_v,
                                         input logic [W-1:0] new_v);
    return (old_v & ~en_v) | (new_v & en_v);
  endfunction

  logic [W-1:0] pen_q, den_q, dval_q, ien_q, pol_q, edge_q, both_q, sts_q;
  logic [W-1:0] pen_d, den_d, dval_d, ien_d, pol_d, edge_d, both_d, sts_d;
  logic [W-1:0] evt, lvl, held;
  logic [W-1:0] val_b, msk_b, lane1, lane2, tmsk;
  logic         do_plain, do_mask;

  assign val_b = wdata_i[W-1:0];
  assign msk_b = wdata_i[2*W-1:W];
  assign lane1 = wdata_i[2*W-1:W];
  assign lane2 = wdata_i[3*W-1:2*W];
  assign tmsk  = wdata_i[4*W-1:3*W];

  assign do_plain = sel_i & cmd_i.plain;
  assign do_mask  = sel_i & cmd_i.masked;

  irq_sense #(.WIDTH(W)) u_sense (
    .cur_i  (cur_i),
    .prev_i (prev_i),
    .pol_i  (pol_q),
    .both_i (both_q),
    .evt_o  (evt),
    .lvl_o  (lvl)
  );

  always_comb begin
    pen_d  = pen_q;
    den_d  = den_q;
    dval_d = dval_q;
    ien_d  = ien_q;
    pol_d  = pol_q;
    edge_d = edge_q;
    both_d = both_q;
    if (do_plain) begin
      unique case (cmd_i.grp)
        GRP_PEN:  pen_d  = val_b;
        GRP_DEN:  den_d  = val_b;
        GRP_DVAL: dval_d = val_b;
        GRP_IEN:  ien_d  = val_b;
        GRP_TYPE: begin
          pol_d  = val_b;
          edge_d = lane1;
          both_d = lane2;
        end
        default: ;
      endcase
    end
    if (do_mask) begin
      unique case (cmd_i.grp)
        GRP_PEN:  pen_d  = merge(pen_q, msk_b, val_b);
        GRP_DEN:  den_d  = merge(den_q, msk_b, val_b);
        GRP_DVAL: dval_d = merge(dval_q, msk_b, val_b);
        GRP_IEN:  ien_d  = merge(ien_q, msk_b, val_b);
        GRP_TYPE: begin
          pol_d  = merge(pol_q, tmsk, val_b);
          edge_d = merge(edge_q, tmsk, lane1);
          both_d = merge(both_q, tmsk, lane2);
        end
        default: ;
      endcase
    end
  end

  // status: software effects first, then a fresh edge overrides them
  always_comb begin
    held = sts_q;
    if (do_plain && cmd_i.grp == GRP_CLR) held = held & ~val_b;
    if (do_mask && cmd_i.grp == GRP_STS)  held = merge(held, msk_b, val_b);
    sts_d = (edge_q & (held | evt)) | (~edge_q & lvl);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_q  <= '0;
      den_q  <= '0;
      dval_q <= '0;
      ien_q  <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      sts_q  <= '0;
    end else begin
      pen_q  <= pen_d;
      den_q  <= den_d;
      dval_q <= dval_d;
      ien_q  <= ien_d;
      pol_q  <= pol_d;
      edge_q <= edge_d;
      both_q <= both_d;
      sts_q  <= sts_d;
    end
  end

  assign pen_o  = pen_q;
  assign den_o  = den_q;
  assign dval_o = dval_q;
  assign ien_o  = ien_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
  assign both_o = both_q;
  assign sts_o  = sts_q;

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  parameter int ALIAS_BIT = 7,
  parameter int SYNC_STG  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [PORT_W*NUM_PORTS-1:0]   pad_in,
  output logic [PORT_W*NUM_PORTS-1:0]   pad_out,
  output logic [PORT_W*NUM_PORTS-1:0]   pad_oe,
  output logic                          irq
);

  localparam int PINS   = PORT_W * NUM_PORTS;
  localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int PORT_LSB = 2;
  localparam int GRP_LSB  = 4;

  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  // decode
  logic [PSEL_W-1:0] port_sel;
  grp_e              grp;
  logic              alias_sel;
  wr_cmd_t           cmd;
  logic              unused_bits;

  assign port_sel  = bus_addr[PORT_LSB +: PSEL_W];
  assign grp       = grp_e'(bus_addr[GRP_LSB +: 3]);
  assign alias_sel = bus_addr[ALIAS_BIT];
  assign cmd.plain  = bus_wr & ~alias_sel;
  assign cmd.masked = bus_wr & alias_sel;
  assign cmd.grp    = grp;
  assign unused_bits = ^bus_addr[1:0];

  // synchronised inputs
  logic [PINS-1:0] cur_v, prev_v;
  pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_ni (rst_i),
    .raw_i  (pad_in),
    .cur_o  (cur_v),
    .prev_o (prev_v)
  );

  logic [PINS-1:0] pen_v, den_v, dval_v, ien_v, pol_v, edge_v, both_v, sts_v;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_regs #(.W(PORT_W)) u_port (
      .clk     (clk),
      .rst_ni  (rst_i),
      .sel_i   (port_sel == PSEL_W'(p)),
      .cmd_i   (cmd),
      .wdata_i (bus_wdata),
      .cur_i   (cur_v[p*PORT_W +: PORT_W]),
      .prev_i  (prev_v[p*PORT_W +: PORT_W]),
      .pen_o   (pen_v[p*PORT_W +: PORT_W]),
      .den_o   (den_v[p*PORT_W +: PORT_W]),
      .dval_o  (dval_v[p*PORT_W +: PORT_W]),
      .ien_o   (ien_v[p*PORT_W +: PORT_W]),
      .pol_o   (pol_v[p*PORT_W +: PORT_W]),
      .edge_o  (edge_v[p*PORT_W +: PORT_W]),
      .both_o  (both_v[p*PORT_W +: PORT_W]),
      .sts_o   (sts_v[p*PORT_W +: PORT_W])
    );
  end

  // read path, registered
  logic [31:0] rdata_d, rdata_q;
  int          base;

  always_comb begin
    base    = int'(port_sel) * PORT_W;
    rdata_d = '0;
    unique case (grp)
      GRP_PEN:  rdata_d[PORT_W-1:0] = pen_v[base +: PORT_W];
      GRP_DEN:  rdata_d[PORT_W-1:0] = den_v[base +: PORT_W];
      GRP_DVAL: rdata_d[PORT_W-1:0] = dval_v[base +: PORT_W];
      GRP_IN:   rdata_d[PORT_W-1:0] = cur_v[base +: PORT_W];
      GRP_STS:  rdata_d[PORT_W-1:0] = sts_v[base +: PORT_W];
      GRP_IEN:  rdata_d[PORT_W-1:0] = ien_v[base +: PORT_W];
      GRP_TYPE: rdata_d[3*PORT_W-1:0] = {both_v[base +: PORT_W],
                                         edge_v[base +: PORT_W],
                                         pol_v[base +: PORT_W]};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_oe    = pen_v & den_v;
  assign pad_out   = dval_v & pen_v & den_v;
  assign irq       = |(sts_v & ien_v);

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
  parameter int PINS      = 32,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int ALIAS_BIT = 7
) (
  input logic              clk,
  input logic              rst_i,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [PINS-1:0]   dval_v,
  input logic [PINS-1:0]   sts_v,
  input logic [PINS-1:0]   edge_v,
  input logic [PINS-1:0]   pol_v,
  input logic [PINS-1:0]   ien_v,
  input logic [PINS-1:0]   cur_v,
  input logic [PINS-1:0]   pad_oe
);

  logic [PINS-1:0] keep_m, clr_m;
  int              sh;
  logic            is_alias;
  logic [2:0]      g;

  always_comb begin
    sh       = int'(bus_addr[3:2]) * PORT_W;
    is_alias = bus_addr[ALIAS_BIT];
    g        = bus_addr[6:4];
    keep_m   = ~(PINS'(bus_wdata[2*PORT_W-1:PORT_W]) << sh);
    clr_m    = PINS'(bus_wdata[PORT_W-1:0]) << sh;
  end

  // R2: masked drive-value write leaves unselected pins alone
  a_r2_masked_keep: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_wr && is_alias && g == 3'd2) |=> (((dval_v ^ $past(dval_v)) & $past(keep_m)) == '0));

  // R4: pad drive enable moves only after a write
  a_r4_pad_stable: assert property (@(posedge clk) disable iff (!rst_i)
    !bus_wr |=> $stable(pad_oe));

  // R6: a latched edge status cannot drop without a bus write
  a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !bus_wr |=> (((~sts_v) & $past(sts_v & edge_v)) == '0));

  // R7: level-mode status equals the qualified synchronised level
  a_r7_level_follow: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> (((sts_v ^ ~($past(pol_v) ^ $past(cur_v))) & ~$past(edge_v)) == '0));

  // R8: a clear write never removes an edge status whose clear bit is 0
  a_r8_clear_only_ones: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_wr && !is_alias && g == 3'd7) |=> (((~sts_v) & $past(sts_v & edge_v & ~clr_m)) == '0));

  // R9: interrupt enables come out of reset cleared
  a_r9_ien_reset: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rst_i) |-> (ien_v == '0));

endmodule

bind pinbank_ctrl pinbank_chk #(
  .PINS(PINS), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .ALIAS_BIT(ALIAS_BIT)
) u_chk (
  .clk       (clk),
  .rst_i     (rst_i),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .dval_v    (dval_v),
  .sts_v     (sts_v),
  .edge_v    (edge_v),
  .pol_v     (pol_v),
  .ien_v     (ien_v),
  .cur_v     (cur_v),
  .pad_oe    (pad_oe)
);

// File: tb/test_pinbank_ctrl.sv
module test_pinbank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int    n_tests = 0, n_fail = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string tag = "R1";

  always #4 clk = ~clk;   // 125 MHz

  pinbank_ctrl i_pinbank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_pen, m_den, m_dval, m_ien, m_pol, m_edg, m_both, m_sts;
  bit [31:0] m_s1, m_s2, m_s3, m_rdata;
  int        m_rcnt = 0;

  function automatic bit [7:0] mbyte(bit [31:0] v, int p);
    return v[p*8 +: 8];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pen = 0; m_den = 0; m_dval = 0; m_ien = 0; m_pol = 0; m_edg = 0;
      m_both = 0; m_sts = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rdata = 0;
      m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      int p, g;
      bit al;
      bit [31:0] nsts;
      p  = int'(bus_addr[3:2]);
      g  = int'(bus_addr[6:4]);
      al = bus_addr[7];
      if (bus_rd) begin
        case (g)
          0: m_rdata = {24'd0, mbyte(m_pen, p)};
          1: m_rdata = {24'd0, mbyte(m_den, p)};
          2: m_rdata = {24'd0, mbyte(m_dval, p)};
          3: m_rdata = {24'd0, mbyte(m_s2, p)};
          4: m_rdata = {24'd0, mbyte(m_sts, p)};
          5: m_rdata = {24'd0, mbyte(m_ien, p)};
          6: m_rdata = {8'd0, mbyte(m_both, p), mbyte(m_edg, p), mbyte(m_pol, p)};
          default: m_rdata = 0;
        endcase
      end
      for (int i = 0; i < 32; i++) begin
        bit ev, held;
        int b;
        b = i % 8;
        if (m_both[i]) ev = (m_s2[i] != m_s3[i]);
        else if (m_pol[i]) ev = m_s2[i] && !m_s3[i];
        else ev = !m_s2[i] && m_s3[i];
        held = m_sts[i];
        if (bus_wr && !al && g == 7 && p == i / 8 && bus_wdata[b]) held = 0;
        if (bus_wr && al && g == 4 && p == i / 8 && bus_wdata[8+b]) held = bus_wdata[b];
        nsts[i] = m_edg[i] ? (held | ev) : (m_s2[i] == m_pol[i]);
      end
      if (bus_wr) begin
        for (int b = 0; b < 8; b++) begin
          int i;
          i = p * 8 + b;
          if (!al) begin
            case (g)
              0: m_pen[i]  = bus_wdata[b];
              1: m_den[i]  = bus_wdata[b];
              2: m_dval[i] = bus_wdata[b];
              5: m_ien[i]  = bus_wdata[b];
              6: begin
                m_pol[i] = bus_wdata[b]; m_edg[i] = bus_wdata[8+b]; m_both[i] = bus_wdata[16+b];
              end
              default: ;
            endcase
          end else begin
            if (bus_wdata[8+b]) begin
              case (g)
                0: m_pen[i]  = bus_wdata[b];
                1: m_den[i]  = bus_wdata[b];
                2: m_dval[i] = bus_wdata[b];
                5: m_ien[i]  = bus_wdata[b];
                default: ;
              endcase
            end
            if (g == 6 && bus_wdata[24+b]) begin
              m_pol[i] = bus_wdata[b]; m_edg[i] = bus_wdata[8+b]; m_both[i] = bus_wdata[16+b];
            end
          end
        end
      end
      m_sts = nsts;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit [31:0] e_oe;
      bit        e_irq;
      e_oe  = m_pen & m_den;
      e_irq = |(m_sts & m_ien);
      n_tests += 4;
      if (irq !== e_irq) begin
        n_fail++; $display("FAIL R9 irq (%s): got %0b exp %0b", tag, irq, e_irq);
      end
      if (pad_oe !== e_oe) begin
        n_fail++; $display("FAIL R4 pad_oe (%s): got %h exp %h", tag, pad_oe, e_oe);
      end
      if (pad_out !== (m_dval & e_oe)) begin
        n_fail++; $display("FAIL R4 pad_out (%s): got %h exp %h", tag, pad_out, m_dval & e_oe);
      end
      if (bus_rdata !== m_rdata) begin
        n_fail++; $display("FAIL %s rdata: got %h exp %h", tag, bus_rdata, m_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_check(input bit [7:0] a, input bit [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    n_tests++;
    if (bus_rdata !== exp) begin
      n_fail++; $display("FAIL %s read %h: got %h exp %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_check(input bit exp, input string req);
    n_tests++;
    if (irq !== exp) begin
      n_fail++; $display("FAIL %s irq: got %0b exp %0b", req, irq, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    bit [31:0] lfsr;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    chk_on = 1;

    // R10: write at the second edge after release is lost
    tag = "R10";
    wr(8'h00, 32'hFF);
    rd_check(8'h00, 32'h0, "R10");

    // R9: enables cleared by reset; R7: level-low status on low pins
    tag = "R9";
    for (int p = 0; p < 4; p++) rd_check(8'h50 + 8'(4*p), 32'h0, "R9");
    irq_check(1'b0, "R9");
    tag = "R7";
    rd_check(8'h40, 32'hFF, "R7");

    // R4/R2: pin enable, drive enable, drive value, masked updates
    tag = "R4";
    wr(8'h00, 32'hFF);
    wr(8'h10, 32'h0F);
    wr(8'h20, 32'hA5);
    n_tests++;
    if (pad_out[7:0] !== 8'h05 || pad_oe[7:0] !== 8'h0F) begin
      n_fail++; $display("FAIL R4 pads: got %h/%h exp 05/0f", pad_out[7:0], pad_oe[7:0]);
    end
    tag = "R2";
    wr(8'hA0, 32'h0000_0302);
    rd_check(8'h20, 32'hA6, "R2");
    wr(8'h90, 32'h0000_F0F0);
    rd_check(8'h10, 32'hFF, "R2");

    // R5/R11: synchronised input visible with drive enabled; writes ignored
    tag = "R5";
    pad_in[7:0] = 8'h3C;
    idle(3);
    wr(8'h30, 32'hFF);
    wr(8'hB0, 32'hFFFF);
    rd_check(8'h30, 32'h3C, "R5");
    tag = "R11";
    wr(8'hF0, 32'h0000_FFFF);
    rd_check(8'h30, 32'h3C, "R11");

    // R3/R6/R8: rising edges on port 1
    tag = "R3";
    wr(8'h64, 32'h0000_FFFF);
    rd_check(8'h64, 32'h0000_FFFF, "R3");
    wr(8'h54, 32'hFF);
    tag = "R8";
    wr(8'h74, 32'hFF);
    idle(1);
    irq_check(1'b0, "R8");
    tag = "R6";
    pad_in[8] = 1;
    idle(4);
    irq_check(1'b1, "R6");
    wr(8'h74, 32'h00);
    irq_check(1'b1, "R8");
    rd_check(8'h74, 32'h0, "R8");
    tag = "R11";
    wr(8'h44, 32'h00);
    irq_check(1'b1, "R11");
    tag = "R2";
    wr(8'hC4, 32'h0000_0100);
    irq_check(1'b0, "R2");
    // edge arriving in the same cycle as its clear wins
    tag = "R6";
    pad_in[9] = 1;
    @(negedge clk);
    wr(8'h74, 32'h02);
    idle(1);
    irq_check(1'b1, "R6");
    wr(8'h74, 32'h02);
    idle(1);
    irq_check(1'b0, "R6");

    // R6: falling and both-edge detection on port 2
    wr(8'h54, 32'h00);
    wr(8'h68, 32'h00FF_FF00);
    wr(8'h78, 32'hFF);
    wr(8'h58, 32'hFF);
    pad_in[16] = 1;
    idle(4);
    irq_check(1'b1, "R6");
    wr(8'h78, 32'hFF);
    idle(1);
    irq_check(1'b0, "R6");
    wr(8'hE8, 32'h0200_0200);   // pin 17: falling only
    pad_in[17] = 1;
    idle(4);
    irq_check(1'b0, "R6");
    pad_in[17] = 0;
    idle(4);
    irq_check(1'b1, "R6");
    wr(8'h78, 32'hFF);
    wr(8'h58, 32'h00);

    // R7/R3: level high on port 3 pin 0 via masked type write
    tag = "R3";
    wr(8'hEC, 32'h0100_0001);
    rd_check(8'h6C, 32'h0000_0001, "R3");
    wr(8'h5C, 32'h01);
    idle(2);
    irq_check(1'b0, "R7");
    tag = "R7";
    pad_in[24] = 1;
    idle(4);
    irq_check(1'b1, "R7");
    wr(8'h7C, 32'h01);
    idle(1);
    irq_check(1'b1, "R7");
    pad_in[24] = 0;
    idle(4);
    irq_check(1'b0, "R7");

    // mixed traffic with every mode enabled, compared against the model
    tag = "R9";
    for (int p = 0; p < 4; p++) wr(8'h54 + 8'(4*p) - 8'h04, 32'hFF);
    wr(8'h60, 32'h0033_F0AA);
    lfsr = 32'h1234_5678;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pad_in = lfsr;
      if (k % 17 == 0) wr(8'h70 + 8'(4 * (k % 4)), lfsr);
      if (k % 29 == 0) begin
        bus_rd = 1; bus_addr = 8'h40 + 8'(4 * (k % 4));
        @(negedge clk);
        bus_rd = 0;
      end
    end
    idle(4);
    finish_run();
  end

endmodule